// File: doc/BRIEF.md
# Triggered Sample Capture Controller

This block decides, cycle by cycle, which converted samples are pushed into a capture FIFO. A mode field selects one of five behaviours: a power-on uninitialized state, a clearing reset, a pause that holds every counter, a single-shot capture and a capture that re-arms itself. While a capture mode runs, a four-state trigger machine first fills a programmable pre-start window. It then keeps that window fresh while it waits for a start pulse, stores every sample until a stop pulse, and finally stores a programmable number of trailing samples.

The block sits between a converter's sample stream and a FIFO. It asks the converter to initialize the first time it leaves the uninitialized mode and captures nothing until the converter reports that initialization is done. It drives a write strobe and a discard strobe, the discard removing the oldest FIFO entry. It reports its trigger state, the mode in force, a running count of stored samples and a one-cycle done pulse.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After reset the mode readback is 0x4 (uninitialized), the trigger state is 0, the sample count is 0, and no FIFO write, discard or done pulse occurs. Trigger state codes: 0 pre-start fill, 1 wait for start, 2 capture, 3 post-stop.
- R2: When a mode other than 0x4 is in force and initialization has not yet completed, the init request is high and no sample is stored. A cycle with init done high ends the request for good.
- R3: Only mode codes 0x0 (reset), 0x1 (pause), 0x2 (single-shot) and 0x3 (re-arm) are accepted. A write of 0x4 or any code above 0x4 leaves the mode unchanged.
- R4: In reset or uninitialized mode, the trigger state returns to 0 and the sample count clears one cycle later, and nothing is written.
- R5: In pause mode nothing is written, and the trigger state and sample count hold their values.
- R6: In state 0 each valid sample is written. After W samples, where W is the smaller of the programmed pre-start count and the FIFO depth, the state becomes 1. A start pulse in state 0 is ignored.
- R7: In state 1 with W > 0, each valid sample is written, and the discard strobe is raised with it when the FIFO level is at least W. With W = 0, no sample is written in state 1.
- R8: A stop pulse in state 0 or 1 is ignored. A start pulse in state 1 moves to state 2, and from then on every valid sample is written.
- R9: A stop pulse in state 2 moves to state 3. Exactly the programmed post-stop count of further samples is written, after which writing stops.
- R10: In single-shot mode, completion of the post-stop samples raises the done output for exactly one cycle, and no further samples are written until reset mode is written.
- R11: In re-arm mode, once the post-stop samples are written and the FIFO reports empty, the state returns to 0 and pre-start filling restarts. No done pulse is produced.
- R12: The sample count rises by one with each FIFO write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample word |
| trig_start | input | 1 | Start trigger pulse |
| trig_stop | input | 1 | Stop trigger pulse |
| mode_we | input | 1 | Mode write enable |
| mode_wdata | input | 4 | Mode code to write |
| pre_count | input | CNT_W | Programmed pre-start window |
| post_count | input | CNT_W | Programmed post-stop sample count |
| fifo_level | input | LVL_W | Current FIFO occupancy |
| fifo_empty | input | 1 | FIFO empty flag |
| conv_init_done | input | 1 | Converter initialization complete |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | DATA_W | FIFO write data |
| fifo_discard | output | 1 | Drop oldest FIFO entry |
| conv_init_req | output | 1 | Converter initialization request |
| mode_rd | output | 4 | Mode in force |
| trig_state | output | 2 | Trigger state code |
| capture_done | output | 1 | Single-shot completion pulse |
| sample_count | output | CNT_W | Samples written since last clear |

## Verification
The bench places a start pulse inside the pre-start fill and a stop pulse during the wait for start. A design that honours them too early would store the wrong window or jump straight into post-stop. It lets the pre-start window fill and checks that the oldest entry is discarded as each new sample arrives. A missing discard would let the window grow without bound. It pauses in the middle of a capture, which catches a design that clears its counters or keeps writing. It also runs a zero-length pre-start window, a re-arm that must stall until the FIFO empties, and a pre-start count larger than the FIFO, which catches a design that does not clamp the window and would wait in state 0 forever.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [3:0] {
    MD_RESET  = 4'h0,
    MD_PAUSE  = 4'h1,
    MD_SINGLE = 4'h2,
    MD_REARM  = 4'h3,
    MD_UNINIT = 4'h4
  } mode_e;

  typedef enum logic [1:0] {
    TS_PRE  = 2'd0,
    TS_WAIT = 2'd1,
    TS_CAPT = 2'd2,
    TS_POST = 2'd3
  } tstate_e;
endpackage

// File: rtl/cap_mode_reg.sv
module cap_mode_reg
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [3:0] mode_wdata,
  input  logic       init_done,
  output mode_e      mode_o,
  output logic       init_req_o,
  output logic       run_o,
  output logic       clr_o,
  output logic       rearm_o
);
  mode_e mode_q, mode_d;
  logic  init_ok_q, init_ok_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_we && (mode_wdata <= 4'h3)) mode_d = mode_e'(mode_wdata);
  end

  assign init_req_o = (mode_q != MD_UNINIT) && !init_ok_q;
  assign init_ok_d  = init_ok_q | (init_req_o & init_done);
  assign run_o      = init_ok_q && ((mode_q == MD_SINGLE) || (mode_q == MD_REARM));
  assign clr_o      = (mode_q == MD_UNINIT) || (mode_q == MD_RESET);
  assign rearm_o    = (mode_q == MD_REARM);
  assign mode_o     = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_UNINIT;
      init_ok_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      init_ok_q <= init_ok_d;
    end
  end

  // R3: codes above 3 never change the mode
  assert_bad_code_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && (mode_wdata > 4'h3)) |=> $stable(mode_q));

  // R2: no capture permission while initialization is pending
  assert_no_run_before_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_req_o |-> !run_o);
endmodule

// File: rtl/cap_trig_fsm.sv
module cap_trig_fsm
  import cap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 16,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic              rearm_i,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CNT_W-1:0]  pre_cnt,
  input  logic [CNT_W-1:0]  post_cnt,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              fifo_empty,
  output logic              fifo_we_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  output logic              fifo_discard_o,
  output logic              done_o,
  output tstate_e           state_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO    = '0;

  tstate_e           st_q, st_d;
  logic [CNT_W-1:0]  fill_q, fill_d, left_q, left_d, cnt_q, cnt_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              we_q, we_d, disc_q, disc_d, done_q, done_d;
  logic [CNT_W-1:0]  pre_eff, lvl_ext;

  assign pre_eff = (pre_cnt > DEPTH_C) ? DEPTH_C : pre_cnt;
  assign lvl_ext = CNT_W'(fifo_level);

  always_comb begin
    st_d    = st_q;
    fill_d  = fill_q;
    left_d  = left_q;
    cnt_d   = cnt_q;
    wdata_d = wdata_q;
    we_d    = 1'b0;
    disc_d  = 1'b0;
    done_d  = 1'b0;
    if (clr_i) begin
      st_d   = TS_PRE;
      fill_d = ZERO;
      left_d = ZERO;
      cnt_d  = ZERO;
    end else if (run_i) begin
      case (st_q)
        TS_PRE: begin
          if (fill_q >= pre_eff) begin
            st_d = TS_WAIT;
          end else if (smp_valid) begin
            we_d   = 1'b1;
            fill_d = fill_q + ONE;
            if ((fill_q + ONE) >= pre_eff) st_d = TS_WAIT;
          end
        end
        TS_WAIT: begin
          if (start_i) begin
            st_d = TS_CAPT;
            we_d = smp_valid;
          end else if (smp_valid && (pre_eff != ZERO)) begin
            we_d   = 1'b1;
            disc_d = (lvl_ext >= pre_eff);
          end
        end
        TS_CAPT: begin
          we_d = smp_valid;
          if (stop_i) begin
            st_d   = TS_POST;
            left_d = post_cnt;
            done_d = (post_cnt == ZERO) && !rearm_i;
          end
        end
        default: begin
          if (left_q == ZERO) begin
            if (rearm_i && fifo_empty) begin
              st_d   = TS_PRE;
              fill_d = ZERO;
            end
          end else if (smp_valid) begin
            we_d   = 1'b1;
            left_d = left_q - ONE;
            done_d = (left_q == ONE) && !rearm_i;
          end
        end
      endcase
      if (we_d) begin
        cnt_d   = cnt_q + ONE;
        wdata_d = smp_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TS_PRE;
      fill_q  <= '0;
      left_q  <= '0;
      cnt_q   <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      disc_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      fill_q  <= fill_d;
      left_q  <= left_d;
      cnt_q   <= cnt_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
      disc_q  <= disc_d;
      done_q  <= done_d;
    end
  end

  assign fifo_we_o      = we_q;
  assign fifo_wdata_o   = wdata_q;
  assign fifo_discard_o = disc_q;
  assign done_o         = done_q;
  assign state_o        = st_q;
  assign count_o        = cnt_q;

  // R4: a clearing mode returns state and count to their initial values
  assert_clear_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (st_q == TS_PRE) && (cnt_q == ZERO));

  // R5: no write follows a cycle without run permission
  assert_idle_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !we_q);

  // R8: stop before start never reaches post-stop
  assert_stop_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == TS_PRE) || (st_q == TS_WAIT)) |=> (st_q != TS_POST));

  // R9: a finished post-stop window writes nothing more
  assert_post_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == TS_POST) && (left_q == ZERO)) |=> !we_q);

  // R10: done lasts a single cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
  import cap_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              trig_start,
  input  logic              trig_stop,
  input  logic              mode_we,
  input  logic [3:0]        mode_wdata,
  input  logic [CNT_W-1:0]  pre_count,
  input  logic [CNT_W-1:0]  post_count,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              fifo_empty,
  input  logic              conv_init_done,
  output logic              fifo_we,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              fifo_discard,
  output logic              conv_init_req,
  output logic [3:0]        mode_rd,
  output logic [1:0]        trig_state,
  output logic              capture_done,
  output logic [CNT_W-1:0]  sample_count
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  mode_e      mode;
  tstate_e    st;
  logic       run, clr, rearm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cap_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .init_done  (conv_init_done),
    .mode_o     (mode),
    .init_req_o (conv_init_req),
    .run_o      (run),
    .clr_o      (clr),
    .rearm_o    (rearm)
  );

  cap_trig_fsm #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .DEPTH  (FIFO_DEPTH),
    .LVL_W  (LVL_W)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .run_i          (run),
    .clr_i          (clr),
    .rearm_i        (rearm),
    .smp_valid      (smp_valid),
    .smp_data       (smp_data),
    .start_i        (trig_start),
    .stop_i         (trig_stop),
    .pre_cnt        (pre_count),
    .post_cnt       (post_count),
    .fifo_level     (fifo_level),
    .fifo_empty     (fifo_empty),
    .fifo_we_o      (fifo_we),
    .fifo_wdata_o   (fifo_wdata),
    .fifo_discard_o (fifo_discard),
    .done_o         (capture_done),
    .state_o        (st),
    .count_o        (sample_count)
  );

  assign mode_rd    = mode;
  assign trig_state = st;
endmodule

// File: tb/trig_capture_ctrl_tb.sv
module trig_capture_ctrl_tb;
  localparam int DW = 16, CW = 16, DEP = 16, LW = $clog2(DEP + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_valid, trig_start, trig_stop, mode_we, fifo_empty, init_done;
  logic [DW-1:0] smp_data;
  logic [3:0]    mode_wdata;
  logic [CW-1:0] pre_count, post_count;
  logic [LW-1:0] fifo_level;
  logic          fifo_we, fifo_discard, init_req, cap_done;
  logic [DW-1:0] fifo_wdata;
  logic [3:0]    mode_rd;
  logic [1:0]    trig_state;
  logic [CW-1:0] sample_count;

  int total = 0, bad = 0, n_disc = 0, n_done = 0, lvl = 0;
  bit finished = 0;
  logic [DW-1:0] expq[$];

  always #5 clk = ~clk;

  trig_capture_ctrl #(.DATA_W(DW), .CNT_W(CW), .FIFO_DEPTH(DEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .trig_start(trig_start), .trig_stop(trig_stop), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .pre_count(pre_count), .post_count(post_count),
    .fifo_level(fifo_level), .fifo_empty(fifo_empty), .conv_init_done(init_done),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .fifo_discard(fifo_discard),
    .conv_init_req(init_req), .mode_rd(mode_rd), .trig_state(trig_state),
    .capture_done(cap_done), .sample_count(sample_count)
  );

  assign fifo_level = LW'(lvl);

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every write
  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_we) begin
        total++;
        if (expq.size() == 0) begin
          bad++;
          $display("FAIL R6-R9 unexpected write actual=%0h expected=none", fifo_wdata);
        end else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          if (fifo_wdata != e) begin
            bad++;
            $display("FAIL R6-R9 write data actual=%0h expected=%0h", fifo_wdata, e);
          end
        end
        if (!fifo_discard) lvl++;
      end
      if (fifo_discard) n_disc++;
      if (cap_done) n_done++;
    end
  end

  task automatic cyc(input bit v, input logic [DW-1:0] d, input bit st, input bit sp, input bit exp);
    smp_valid = v; smp_data = d; trig_start = st; trig_stop = sp;
    if (exp) expq.push_back(d);
    @(negedge clk);
    smp_valid = 0; trig_start = 0; trig_stop = 0;
  endtask

  task automatic wmode(input logic [3:0] code);
    mode_we = 1; mode_wdata = code;
    @(negedge clk);
    mode_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; smp_valid = 0; smp_data = '0; trig_start = 0; trig_stop = 0;
    mode_we = 0; mode_wdata = '0; fifo_empty = 0; init_done = 0;
    pre_count = 3; post_count = 2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mode", mode_rd, 4);
    check("R1 state", trig_state, 0);
    check("R1 count", sample_count, 0);
    check("R1 init_req", init_req, 0);
    cyc(1, 16'h0BAD, 1, 0, 0);
    check("R4 uninit no capture", sample_count, 0);
    // R3 illegal code
    wmode(4'h5);
    check("R3 code 5 ignored", mode_rd, 4);
    // R2 init handshake
    wmode(4'h2);
    check("R2 init_req high", init_req, 1);
    cyc(1, 16'h0BAE, 0, 0, 0);
    check("R2 no capture before init", sample_count, 0);
    init_done = 1; @(negedge clk); init_done = 0;
    check("R2 init_req cleared", init_req, 0);
    wmode(4'h9);
    check("R3 code 9 ignored", mode_rd, 2);
    // R6 pre-start, start ignored
    cyc(1, 16'hA001, 1, 0, 1);
    check("R6 start ignored in pre", trig_state, 0);
    cyc(1, 16'hA002, 0, 0, 1);
    cyc(1, 16'hA003, 0, 0, 1);
    check("R6 window full", trig_state, 1);
    // R8 stop ignored in wait
    cyc(0, 16'h0, 0, 1, 0);
    check("R8 stop ignored", trig_state, 1);
    // R7 discard oldest
    cyc(1, 16'hA004, 0, 0, 1);
    cyc(1, 16'hA005, 0, 0, 1);
    cyc(0, 16'h0, 0, 0, 0);
    check("R7 discards", n_disc, 2);
    // R8 start
    cyc(1, 16'hA006, 1, 0, 1);
    check("R8 capture state", trig_state, 2);
    cyc(1, 16'hA007, 0, 0, 1);
    // R5 pause
    wmode(4'h1);
    cyc(1, 16'h0BAF, 0, 0, 0);
    cyc(1, 16'h0BB0, 0, 0, 0);
    check("R5 state held", trig_state, 2);
    check("R5 count held", sample_count, 7);
    wmode(4'h2);
    // R9 post-stop
    cyc(1, 16'hA008, 0, 1, 1);
    check("R9 post state", trig_state, 3);
    cyc(1, 16'hA009, 0, 0, 1);
    cyc(1, 16'hA00A, 0, 0, 1);
    cyc(1, 16'h0BB1, 0, 0, 0);
    cyc(1, 16'h0BB2, 1, 0, 0);
    check("R10 done once", n_done, 1);
    check("R12 sample count", sample_count, 10);
    // R4 reset mode
    wmode(4'h0);
    cyc(0, 16'h0, 0, 0, 0);
    check("R4 count cleared", sample_count, 0);
    check("R4 state cleared", trig_state, 0);
    // R11 re-arm with zero pre-start window
    pre_count = 0; post_count = 1;
    wmode(4'h3);
    cyc(0, 16'h0, 0, 0, 0);
    check("R7 zero window wait", trig_state, 1);
    cyc(1, 16'h0BB3, 0, 0, 0);
    cyc(1, 16'hB001, 1, 0, 1);
    cyc(1, 16'hB002, 0, 1, 1);
    cyc(1, 16'hB003, 0, 0, 1);
    cyc(0, 16'h0, 0, 0, 0);
    check("R11 waits for empty", trig_state, 3);
    check("R11 no done pulse", n_done, 1);
    fifo_empty = 1;
    cyc(0, 16'h0, 0, 0, 0);
    fifo_empty = 0;
    check("R11 re-armed", trig_state, 0);
    // R6 window clamp to depth
    wmode(4'h0);
    pre_count = 40;
    wmode(4'h2);
    for (int i = 0; i < DEP - 1; i++) cyc(1, DW'(16'hC000 + i), 0, 0, 1);
    check("R6 clamp not yet", trig_state, 0);
    cyc(1, 16'hC0FF, 0, 0, 1);
    check("R6 clamp reached", trig_state, 1);
    check("R12 clamp count", sample_count, DEP);
    cyc(0, 16'h0, 0, 0, 0);
    check("R9 scoreboard drained", expq.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule